// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block sits beside a processor core and decides when the core may stop its clock and when it must be woken. The pipeline raises a one-cycle strobe when it retires a wait-for-interrupt or a wait-for-event instruction. The controller then parks in one of two standby states and drops the core clock enable. Only the controller itself keeps running on the free-running clock. In standby the core stays powered.

The two standby states follow different wake rules. The interrupt-wait state wakes on any interrupt or abort, whatever the status-register mask bits say. The event-wait state respects those masks. It also wakes on the external event line, on an event-send from a peer core, and on a pending event held in a one-bit event flag.

Both states wake on a permitted debug request. When the cluster build parameter is set, both also wake on a cache-maintenance broadcast from another core. Wake inputs that come from outside the clock domain are brought in through a synchronizer chain before they are looked at.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `core_clk_en` is 1, `in_standby` is 0 and `wake_pulse` is 0.
- R2: In Run, a `wfi_req` strobe enters interrupt-wait standby. From the next clock edge `in_standby` is 1 and `core_clk_en` is 0. If `wfi_req` and `wfe_req` are both high in the same cycle, interrupt-wait is chosen.
- R3: In Run, a `wfe_req` strobe with the event flag clear enters event-wait standby, with the same output timing as R2.
- R4: In interrupt-wait, `irq_a`, `fiq_a` or `abort_a` wakes the core even when its mask bit (`mask_i`, `mask_f`, `mask_a`, 1 = masked) is set.
- R5: In event-wait, `irq_a`, `fiq_a` and `abort_a` wake the core only when the matching mask bit is 0.
- R6: In either standby state, a debug request wakes the core only when `dbg_invasive_en` and `dbg_permit` are both 1. The request is `dbg_req_a` (pin) or `dbg_halt` (from the debug port).
- R7: In event-wait, `event_a` or `peer_sev` wakes the core. Neither of them wakes interrupt-wait.
- R8: `maint_bcast` wakes either standby state when `MP_BUILD` is 1, and is ignored when `MP_BUILD` is 0.
- R9: `event_a` or `peer_sev` sets the event flag in any state. A `wfe_req` in Run while the flag is set clears the flag and stays in Run. A wake from event-wait also clears the flag.
- R10: A wake condition seen in a cycle makes `core_clk_en` 1, `in_standby` 0 and `wake_pulse` 1 at the next edge, and `wake_pulse` lasts one cycle. Synchronized inputs (`irq_a`, `fiq_a`, `abort_a`, `dbg_req_a`, `event_a`) pass through `SYNC_STAGES` flops first. With the default of 2, the wake shows at the third edge after the input rises.
- R11: `wfi_req` and `wfe_req` arriving while in standby are ignored and do not change the standby state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the pipeline |
| wfe_req | input | 1 | Wait-for-event strobe from the pipeline |
| irq_a | input | 1 | Interrupt request, asynchronous |
| fiq_a | input | 1 | Fast interrupt request, asynchronous |
| abort_a | input | 1 | Asynchronous abort, asynchronous |
| mask_i | input | 1 | Interrupt mask bit, 1 = masked |
| mask_f | input | 1 | Fast interrupt mask bit, 1 = masked |
| mask_a | input | 1 | Abort mask bit, 1 = masked |
| dbg_req_a | input | 1 | External debug request pin, asynchronous |
| dbg_halt | input | 1 | Halt request from the debug port, synchronous |
| dbg_invasive_en | input | 1 | Invasive debug enabled |
| dbg_permit | input | 1 | Debug event permitted |
| event_a | input | 1 | External event input, asynchronous |
| peer_sev | input | 1 | Event-send from a peer core, synchronous |
| maint_bcast | input | 1 | Cache-maintenance broadcast from a peer, synchronous |
| core_clk_en | output | 1 | Registered enable for the core clock gate |
| in_standby | output | 1 | High while in either standby state |
| wake_pulse | output | 1 | One-cycle pulse on return to Run |

## Verification
The hardest situation to reach from the ports is a wait-for-event strobe that does not sleep because an event is already pending. The bench gets there by pulsing `peer_sev` while in Run and then issuing `wfe_req`. It expects `in_standby` to stay low. A second strobe must then sleep, which shows the flag was consumed.

The second hard case is a strobe that arrives during standby. A `wfe_req` is sent while in interrupt-wait, followed by a masked interrupt. That interrupt wakes only if the state was not switched to event-wait. The mask-dependent wake rules are walked from a vector table, and a second instance built with `MP_BUILD` = 0 shows the broadcast being ignored.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_WAIT_INT = 2'd1,
        ST_WAIT_EVT = 2'd2
    } stby_state_e;

    // Inputs that cross into the clock domain and need synchronizing
    typedef struct packed {
        logic irq;
        logic fiq;
        logic abt;
        logic dbg_pin;
        logic evt;
    } async_src_t;

    localparam int unsigned ASYNC_W = $bits(async_src_t);

    typedef struct packed {
        logic i;
        logic f;
        logic a;
    } psr_mask_t;

    // Qualified wake sources in the clock domain
    typedef struct packed {
        logic irq;
        logic fiq;
        logic abt;
        logic dbg;
        logic evt;
        logic maint;
    } wake_src_t;

    function automatic logic wake_for_int(input wake_src_t s);
        return s.irq | s.fiq | s.abt | s.dbg | s.maint;
    endfunction

    function automatic logic wake_for_evt(input wake_src_t s, input psr_mask_t m);
        return (s.irq & ~m.i) | (s.fiq & ~m.f) | (s.abt & ~m.a)
             | s.dbg | s.evt | s.maint;
    endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/stby_evt_flag.sv
module stby_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Clear wins over a same-cycle set
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (clr_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end
endmodule

// File: rtl/stby_wake_eval.sv
module stby_wake_eval
    import stby_wake_pkg::*;
#(
    parameter bit MP_BUILD = 1'b1
) (
    input  async_src_t sync_src,
    input  psr_mask_t  mask,
    input  logic       dbg_halt,
    input  logic       dbg_invasive_en,
    input  logic       dbg_permit,
    input  logic       peer_sev,
    input  logic       maint_bcast,
    input  logic       evt_flag,
    output logic       evt_now,
    output logic       wake_int,
    output logic       wake_evt
);
    localparam logic MP_EN = MP_BUILD;

    wake_src_t src;

    always_comb begin
        evt_now   = sync_src.evt | peer_sev;
        src.irq   = sync_src.irq;
        src.fiq   = sync_src.fiq;
        src.abt   = sync_src.abt;
        src.dbg   = (sync_src.dbg_pin | dbg_halt) & dbg_invasive_en & dbg_permit;
        src.evt   = evt_now | evt_flag;
        src.maint = maint_bcast & MP_EN;
        wake_int  = wake_for_int(src);
        wake_evt  = wake_for_evt(src, mask);
    end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic evt_flag,
    input  logic wake_int,
    input  logic wake_evt,
    output logic evt_clr,
    output logic core_clk_en,
    output logic in_standby,
    output logic wake_pulse
);
    stby_state_e state, nxt;
    logic        skip_wfe;
    logic        wake_now;

    always_comb begin
        nxt      = state;
        skip_wfe = 1'b0;
        wake_now = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (wfi_req)      nxt = ST_WAIT_INT;
                else if (wfe_req) begin
                    if (evt_flag) skip_wfe = 1'b1;
                    else          nxt = ST_WAIT_EVT;
                end
            end
            ST_WAIT_INT: begin
                if (wake_int) begin
                    nxt      = ST_RUN;
                    wake_now = 1'b1;
                end
            end
            ST_WAIT_EVT: begin
                if (wake_evt) begin
                    nxt      = ST_RUN;
                    wake_now = 1'b1;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    assign evt_clr    = skip_wfe | ((state == ST_WAIT_EVT) & wake_now);
    assign in_standby = (state != ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            core_clk_en <= 1'b1;
            wake_pulse  <= 1'b0;
        end else begin
            state       <= nxt;
            core_clk_en <= (nxt == ST_RUN);
            wake_pulse  <= wake_now;
        end
    end
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import stby_wake_pkg::*;
#(
    parameter bit          MP_BUILD    = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic irq_a,
    input  logic fiq_a,
    input  logic abort_a,
    input  logic mask_i,
    input  logic mask_f,
    input  logic mask_a,
    input  logic dbg_req_a,
    input  logic dbg_halt,
    input  logic dbg_invasive_en,
    input  logic dbg_permit,
    input  logic event_a,
    input  logic peer_sev,
    input  logic maint_bcast,
    output logic core_clk_en,
    output logic in_standby,
    output logic wake_pulse
);
    async_src_t          raw_src, sync_src;
    logic [ASYNC_W-1:0]  sync_q;
    psr_mask_t           mask;
    logic                evt_flag, evt_now, evt_clr;
    logic                wake_int, wake_evt;

    assign raw_src = '{irq: irq_a, fiq: fiq_a, abt: abort_a,
                       dbg_pin: dbg_req_a, evt: event_a};
    assign mask    = '{i: mask_i, f: mask_f, a: mask_a};

    stby_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_src),
        .q   (sync_q)
    );
    assign sync_src = async_src_t'(sync_q);

    stby_wake_eval #(.MP_BUILD(MP_BUILD)) u_eval (
        .sync_src        (sync_src),
        .mask            (mask),
        .dbg_halt        (dbg_halt),
        .dbg_invasive_en (dbg_invasive_en),
        .dbg_permit      (dbg_permit),
        .peer_sev        (peer_sev),
        .maint_bcast     (maint_bcast),
        .evt_flag        (evt_flag),
        .evt_now         (evt_now),
        .wake_int        (wake_int),
        .wake_evt        (wake_evt)
    );

    stby_evt_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_now),
        .clr_i  (evt_clr),
        .flag_o (evt_flag)
    );

    stby_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wfi_req     (wfi_req),
        .wfe_req     (wfe_req),
        .evt_flag    (evt_flag),
        .wake_int    (wake_int),
        .wake_evt    (wake_evt),
        .evt_clr     (evt_clr),
        .core_clk_en (core_clk_en),
        .in_standby  (in_standby),
        .wake_pulse  (wake_pulse)
    );
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk (
    input logic clk,
    input logic rst,
    input logic wfi_req,
    input logic wfe_req,
    input logic core_clk_en,
    input logic in_standby,
    input logic wake_pulse
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (core_clk_en && !in_standby && !wake_pulse));

    // R2
    stby_gates_clk_chk: assert property (@(posedge clk) disable iff (rst)
        in_standby |-> !core_clk_en);

    // R3
    entry_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_standby) |-> $past(wfi_req || wfe_req));

    // R10
    wake_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (core_clk_en && !in_standby));

    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R10
    exit_flags_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_standby) |-> wake_pulse);
endmodule

bind stby_wake_ctrl stby_wake_chk chk_i (.*);

// File: tb/stby_wake_ctrl_tb_top.sv
module stby_wake_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wfi_req = 0, wfe_req = 0;
    logic irq_a = 0, fiq_a = 0, abort_a = 0;
    logic mask_i = 0, mask_f = 0, mask_a = 0;
    logic dbg_req_a = 0, dbg_halt = 0, dbg_invasive_en = 0, dbg_permit = 0;
    logic event_a = 0, peer_sev = 0, maint_bcast = 0;
    logic core_clk_en, in_standby, wake_pulse;
    logic sp_clk_en, sp_stby, sp_pulse;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    stby_wake_ctrl #(.MP_BUILD(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .irq_a(irq_a), .fiq_a(fiq_a), .abort_a(abort_a),
        .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
        .dbg_req_a(dbg_req_a), .dbg_halt(dbg_halt),
        .dbg_invasive_en(dbg_invasive_en), .dbg_permit(dbg_permit),
        .event_a(event_a), .peer_sev(peer_sev), .maint_bcast(maint_bcast),
        .core_clk_en(core_clk_en), .in_standby(in_standby), .wake_pulse(wake_pulse)
    );

    stby_wake_ctrl #(.MP_BUILD(1'b0)) dut_sp (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .irq_a(irq_a), .fiq_a(fiq_a), .abort_a(abort_a),
        .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
        .dbg_req_a(dbg_req_a), .dbg_halt(dbg_halt),
        .dbg_invasive_en(dbg_invasive_en), .dbg_permit(dbg_permit),
        .event_a(event_a), .peer_sev(peer_sev), .maint_bcast(maint_bcast),
        .core_clk_en(sp_clk_en), .in_standby(sp_stby), .wake_pulse(sp_pulse)
    );

    // src: [7]irq [6]fiq [5]abort [4]dbg pin [3]dbg halt [2]event [1]peer sev [0]maint
    // msk: [2]I [1]F [0]A ; den: [1]invasive [0]permit
    typedef struct packed {
        logic       wfe;
        logic [7:0] src;
        logic [2:0] msk;
        logic [1:0] den;
        logic       exp_wake;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'b1000_0000, 3'b100, 2'b00, 1'b1, 8'd4},
        '{1'b0, 8'b0100_0000, 3'b010, 2'b00, 1'b1, 8'd4},
        '{1'b0, 8'b0010_0000, 3'b001, 2'b00, 1'b1, 8'd4},
        '{1'b1, 8'b1000_0000, 3'b100, 2'b00, 1'b0, 8'd5},
        '{1'b1, 8'b1000_0000, 3'b000, 2'b00, 1'b1, 8'd5},
        '{1'b1, 8'b0100_0000, 3'b010, 2'b00, 1'b0, 8'd5},
        '{1'b1, 8'b0010_0000, 3'b000, 2'b00, 1'b1, 8'd5},
        '{1'b1, 8'b0010_0000, 3'b001, 2'b00, 1'b0, 8'd5},
        '{1'b0, 8'b0000_0100, 3'b000, 2'b00, 1'b0, 8'd7},
        '{1'b0, 8'b0000_0010, 3'b000, 2'b00, 1'b0, 8'd7},
        '{1'b1, 8'b0000_0100, 3'b000, 2'b00, 1'b1, 8'd7},
        '{1'b1, 8'b0000_0010, 3'b000, 2'b00, 1'b1, 8'd7},
        '{1'b0, 8'b0000_0001, 3'b000, 2'b00, 1'b1, 8'd8},
        '{1'b1, 8'b0000_0001, 3'b000, 2'b00, 1'b1, 8'd8},
        '{1'b0, 8'b0001_0000, 3'b000, 2'b11, 1'b1, 8'd6},
        '{1'b1, 8'b0000_1000, 3'b000, 2'b10, 1'b0, 8'd6},
        '{1'b0, 8'b0000_1000, 3'b000, 2'b01, 1'b0, 8'd6},
        '{1'b1, 8'b0001_0000, 3'b000, 2'b11, 1'b1, 8'd6}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic drive_src(input logic [7:0] s);
        {irq_a, fiq_a, abort_a, dbg_req_a, dbg_halt, event_a, peer_sev, maint_bcast} = s;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wfi_req = 0; wfe_req = 0;
        drive_src(8'h00);
        {mask_i, mask_f, mask_a} = 3'b000;
        {dbg_invasive_en, dbg_permit} = 2'b00;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic strobe(input logic wfi, input logic wfe);
        wfi_req = wfi; wfe_req = wfe;
        tick();
        wfi_req = 0; wfe_req = 0;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int pulses;
        string tag;

        // Reset state (R1)
        do_reset();
        chk("R1", "core_clk_en", core_clk_en, 1'b1);
        chk("R1", "in_standby", in_standby, 1'b0);
        chk("R1", "wake_pulse", wake_pulse, 1'b0);

        // Vector walk (R2 R3 R4 R5 R6 R7 R8)
        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d", VEC[v].req);
            do_reset();
            {mask_i, mask_f, mask_a}      = VEC[v].msk;
            {dbg_invasive_en, dbg_permit} = VEC[v].den;
            strobe(!VEC[v].wfe, VEC[v].wfe);
            chk(VEC[v].wfe ? "R3" : "R2", "entry in_standby", in_standby, 1'b1);
            chk(VEC[v].wfe ? "R3" : "R2", "entry core_clk_en", core_clk_en, 1'b0);
            drive_src(VEC[v].src);
            pulses = 0;
            for (int k = 0; k < 4; k++) begin
                tick();
                if (wake_pulse === 1'b1) pulses++;
            end
            drive_src(8'h00);
            chk(tag, $sformatf("vec%0d in_standby", v), in_standby, !VEC[v].exp_wake);
            chk(tag, $sformatf("vec%0d core_clk_en", v), core_clk_en, VEC[v].exp_wake);
            chk("R10", $sformatf("vec%0d one-cycle pulse", v), pulses == int'(VEC[v].exp_wake), 1'b1);
        end

        // R10: an asynchronous interrupt wakes at the third edge, not earlier
        do_reset();
        strobe(1'b1, 1'b0);
        irq_a = 1'b1;
        tick();
        tick();
        chk("R10", "still asleep after two edges", in_standby, 1'b1);
        tick();
        chk("R10", "awake at third edge", in_standby, 1'b0);
        chk("R10", "clock enable back", core_clk_en, 1'b1);
        chk("R10", "pulse high", wake_pulse, 1'b1);
        tick();
        chk("R10", "pulse low again", wake_pulse, 1'b0);
        irq_a = 1'b0;

        // R9: pending event makes the wait-for-event strobe fall through
        do_reset();
        peer_sev = 1'b1;
        tick();
        peer_sev = 1'b0;
        strobe(1'b0, 1'b1);
        chk("R9", "pending event skips standby", in_standby, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R9", "flag consumed, second strobe sleeps", in_standby, 1'b1);

        // R9: a wake from event-wait clears the flag
        peer_sev = 1'b1;
        tick();
        peer_sev = 1'b0;
        chk("R9", "woken by peer event", in_standby, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R9", "flag cleared by wake", in_standby, 1'b1);

        // R9: an event during interrupt-wait is remembered
        do_reset();
        strobe(1'b1, 1'b0);
        peer_sev = 1'b1;
        tick();
        peer_sev = 1'b0;
        chk("R7", "peer event leaves interrupt-wait asleep", in_standby, 1'b1);
        maint_bcast = 1'b1;
        tick();
        maint_bcast = 1'b0;
        chk("R8", "broadcast wakes interrupt-wait", in_standby, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R9", "event held from interrupt-wait skips standby", in_standby, 1'b0);

        // R11: a strobe during standby does not change the state
        do_reset();
        mask_i = 1'b1;
        strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R11", "still in standby after strobe", in_standby, 1'b1);
        irq_a = 1'b1;
        tick(); tick(); tick();
        chk("R11", "masked irq wakes, so still interrupt-wait", in_standby, 1'b0);
        irq_a = 1'b0;

        // R2: both strobes together pick interrupt-wait
        do_reset();
        mask_f = 1'b1;
        strobe(1'b1, 1'b1);
        chk("R2", "both strobes enter standby", in_standby, 1'b1);
        fiq_a = 1'b1;
        tick(); tick(); tick();
        chk("R2", "masked fiq wakes interrupt-wait", in_standby, 1'b0);
        fiq_a = 1'b0;

        // R8: build without the broadcast ignores it
        do_reset();
        strobe(1'b1, 1'b0);
        maint_bcast = 1'b1;
        tick(); tick();
        maint_bcast = 1'b0;
        chk("R8", "cluster build wakes", in_standby, 1'b0);
        chk("R8", "single-core build ignores broadcast", sp_stby, 1'b1);
        chk("R8", "single-core clock stays gated", sp_clk_en, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule